// File: doc/BRIEF.md
# Eight-Channel DAC Register Controller

This block is the digital control core of an eight-channel serial digital-to-analog converter. A host shifts 16-bit frames into it, most significant bit first, on the block clock while holding an active-low frame select. Each frame carries a 4-bit register address and 12 data bits. The block stores the data in per-channel pending registers, a preset register or two control registers. Pair addresses load a channel and its bitwise complement in one frame. Before storage, channel data is cut to the configured converter resolution and, if the control word asks for it, converted from twos complement to offset binary.

A load strobe copies all pending values into the output latches that feed the converters. A separate asynchronous preset input, once synchronised, forces every output latch to the stored preset value while the strobe is held. A delayed copy of the serial input can be driven on a serial output so that several devices can share one serial bus in a chain. The power-down and speed settings are brought out only as status bits for the analog side.

Top module: `dac8_regctl`

## Requirements
- R1: After reset every output latch, the preset register, every pending register and every control field are zero, and `sdo` is 0.
- R2: A frame is stored only if exactly 16 bits were shifted while `fs_n` was low; frames of any other length are discarded and change no register.
- R3: A frame with address 0 to 7 updates the pending register of channel A to H (channel n occupies `dac_q[12n+11:12n]`) and no other channel.
- R4: A frame with address 8, 9, 10 or 11 loads channel 2k (k = address − 8) with the converted value and channel 2k+1 with its bitwise complement, both cut to the resolution.
- R5: With resolution parameter RES (12, 10 or 8), data bits below bit 12−RES are stored as zero in channel, pair and preset registers.
- R6: When the format bit is set, channel and pair data have bit 11 inverted after truncation and before storage; preset data is not converted.
- R7: On a clock where `ld` is 1 and was 0 at the previous clock, and the preset is not active, all output latches take the pending values. At no other time do the latches change, except under R8.
- R8: `pre_n` passes through a two-stage synchroniser. On every clock where the synchronised value is 0 and `ld` is 1, all eight latches take the preset register, which is written by address 12.
- R9: Address 13 sets, from data bit 4 down to bit 0: full power-down (`pwr_down`), serial-output enable, reference select (`ref_sel`, 2 bits) and the format bit. Address 14 sets `pair_pd` from bits 7:4 and `pair_fast` from bits 3:0, with bit 0 of each nibble for pair AB. Address 15 is ignored.
- R10: With the serial-output enable set, `sdo` in clock cycle n+16 equals `sdi` in cycle n. With the enable clear, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, MSB first |
| ld | input | 1 | Load strobe for the output latches |
| pre_n | input | 1 | Asynchronous active-low preset request |
| dac_q | output | 96 | Eight 12-bit output latches, channel A lowest |
| sdo | output | 1 | Delayed serial output for chaining |
| pwr_down | output | 1 | Full power-down status |
| ref_sel | output | 2 | Reference select status |
| pair_pd | output | 4 | Per-pair power-down status |
| pair_fast | output | 4 | Per-pair fast-settling status |

## Verification
The hardest case to reach from the ports is the interplay of the strobe with the synchronised preset. A strobe rising edge must be ignored while the preset wins, and the latches must stay frozen when pending data changes under a strobe held high. The stimulus first lowers `pre_n` and waits out the synchroniser before raising `ld`. It then holds `ld` high through further frames and releases the preset before giving a fresh edge. Malformed frames of 15 and 17 bits are sent between good ones, so that a wrong commit would show on the next load.

// File: rtl/dac8_pkg.sv
package dac8_pkg;

  localparam int FRAME_W  = 16;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 12;
  localparam int NUM_CH   = 8;
  localparam int NUM_PAIR = NUM_CH / 2;

  localparam logic [ADDR_W-1:0] A_PRESET = 4'd12;
  localparam logic [ADDR_W-1:0] A_CTRL0  = 4'd13;
  localparam logic [ADDR_W-1:0] A_CTRL1  = 4'd14;

  typedef struct packed {
    logic       pd_all;
    logic       dout_en;
    logic [1:0] ref_sel;
    logic       twos;
  } ctrl0_t;

  typedef struct packed {
    logic [NUM_PAIR-1:0] pd;
    logic [NUM_PAIR-1:0] fast;
  } ctrl1_t;

  function automatic logic [DATA_W-1:0] res_mask(input int res);
    logic [DATA_W-1:0] m;
    m = '1;
    m = m << (DATA_W - res);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] fmt_word(input logic [DATA_W-1:0] d,
                                                  input int res,
                                                  input logic twos);
    logic [DATA_W-1:0] v;
    v = d & res_mask(res);
    if (twos) v[DATA_W-1] = ~v[DATA_W-1];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pair_comp(input logic [DATA_W-1:0] v,
                                                   input int res);
    return ~v & res_mask(res);
  endfunction

endpackage

// File: rtl/dac8_rx.sv
module dac8_rx
  import dac8_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fs_n,
  input  logic               sdi,
  output logic               frame_commit,
  output logic [FRAME_W-1:0] frame_word,
  output logic [4:0]         bit_cnt
);

  localparam logic [4:0] CNT_FULL = 5'(FRAME_W);
  localparam logic [4:0] CNT_OVER = 5'(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [4:0]         cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!fs_n) begin
      sh_q <= {sh_q[FRAME_W-2:0], sdi};
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 5'd1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign frame_commit = fs_n && (cnt_q == CNT_FULL);
  assign frame_word   = sh_q;
  assign bit_cnt      = cnt_q;

endmodule

// File: rtl/dac8_regs.sv
module dac8_regs
  import dac8_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [FRAME_W-1:0]       word,
  output logic [NUM_CH*DATA_W-1:0] pend_flat,
  output logic [DATA_W-1:0]        preset_q,
  output ctrl0_t                   ctrl0_q,
  output ctrl1_t                   ctrl1_q
);

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [DATA_W-1:0] conv;
  logic [DATA_W-1:0] conv_n;

  assign addr   = word[FRAME_W-1:DATA_W];
  assign data   = word[DATA_W-1:0];
  assign conv   = fmt_word(data, RES, ctrl0_q.twos);
  assign conv_n = pair_comp(conv, RES);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR   = ADDR_W'(c);
    localparam logic [ADDR_W-1:0] PAIR_ADDR = ADDR_W'(8 + c / 2);
    localparam bit                IS_UPPER  = (c % 2) == 1;
    logic [DATA_W-1:0] pend_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= '0;
      end else if (commit) begin
        if (addr == CH_ADDR) pend_q <= conv;
        else if (addr == PAIR_ADDR) pend_q <= IS_UPPER ? conv_n : conv;
      end
    end

    assign pend_flat[c*DATA_W +: DATA_W] = pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset_q <= '0;
      ctrl0_q  <= '0;
      ctrl1_q  <= '0;
    end else if (commit) begin
      case (addr)
        A_PRESET: preset_q <= data & res_mask(RES);
        A_CTRL0:  ctrl0_q  <= ctrl0_t'(data[4:0]);
        A_CTRL1:  ctrl1_q  <= ctrl1_t'(data[2*NUM_PAIR-1:0]);
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/dac8_outlat.sv
module dac8_outlat
  import dac8_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld,
  input  logic                     pre_n,
  input  logic [NUM_CH*DATA_W-1:0] pend_flat,
  input  logic [DATA_W-1:0]        preset_q,
  output logic [NUM_CH*DATA_W-1:0] dac_q,
  output logic                     ld_rise,
  output logic                     preset_force
);

  logic pre_s1, pre_s2;
  logic ld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_s1 <= 1'b1;
      pre_s2 <= 1'b1;
      ld_q   <= 1'b0;
    end else begin
      pre_s1 <= pre_n;
      pre_s2 <= pre_s1;
      ld_q   <= ld;
    end
  end

  assign ld_rise      = ld && !ld_q;
  assign preset_force = ld && !pre_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) dac_q <= '0;
    else if (preset_force) dac_q <= {NUM_CH{preset_q}};
    else if (ld_rise) dac_q <= pend_flat;
  end

endmodule

// File: rtl/dac8_chain.sv
module dac8_chain #(
  parameter int DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdi,
  input  logic en,
  output logic sdo
);

  logic [DLY-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= '0;
    else line_q <= {line_q[DLY-2:0], sdi};
  end

  assign sdo = en && line_q[DLY-1];

endmodule

// File: rtl/dac8_regctl.sv
module dac8_regctl
  import dac8_pkg::*;
#(
  parameter int RES   = 12,
  parameter int CHAIN = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fs_n,
  input  logic                     sdi,
  input  logic                     ld,
  input  logic                     pre_n,
  output logic [NUM_CH*DATA_W-1:0] dac_q,
  output logic                     sdo,
  output logic                     pwr_down,
  output logic [1:0]               ref_sel,
  output logic [NUM_PAIR-1:0]      pair_pd,
  output logic [NUM_PAIR-1:0]      pair_fast
);

  logic                     frame_commit;
  logic [FRAME_W-1:0]       frame_word;
  logic [4:0]               bit_cnt;
  logic [NUM_CH*DATA_W-1:0] pend_flat;
  logic [DATA_W-1:0]        preset_q;
  ctrl0_t                   ctrl0_q;
  ctrl1_t                   ctrl1_q;
  logic                     ld_rise;
  logic                     preset_force;
  logic [ADDR_W-1:0]        frm_addr;
  logic                     dout_en;

  assign frm_addr = frame_word[FRAME_W-1:DATA_W];
  assign dout_en  = ctrl0_q.dout_en;

  dac8_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .fs_n         (fs_n),
    .sdi          (sdi),
    .frame_commit (frame_commit),
    .frame_word   (frame_word),
    .bit_cnt      (bit_cnt)
  );

  dac8_regs #(.RES(RES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (frame_commit),
    .word      (frame_word),
    .pend_flat (pend_flat),
    .preset_q  (preset_q),
    .ctrl0_q   (ctrl0_q),
    .ctrl1_q   (ctrl1_q)
  );

  dac8_outlat u_lat (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld           (ld),
    .pre_n        (pre_n),
    .pend_flat    (pend_flat),
    .preset_q     (preset_q),
    .dac_q        (dac_q),
    .ld_rise      (ld_rise),
    .preset_force (preset_force)
  );

  dac8_chain #(.DLY(CHAIN)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .sdi   (sdi),
    .en    (dout_en),
    .sdo   (sdo)
  );

  assign pwr_down  = ctrl0_q.pd_all;
  assign ref_sel   = ctrl0_q.ref_sel;
  assign pair_pd   = ctrl1_q.pd;
  assign pair_fast = ctrl1_q.fast;

endmodule

// File: rtl/dac8_regctl_chk.sv
module dac8_regctl_chk
  import dac8_pkg::*;
#(
  parameter int RES = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_commit,
  input logic [ADDR_W-1:0]        frm_addr,
  input logic [4:0]               bit_cnt,
  input logic [NUM_CH*DATA_W-1:0] pend_flat,
  input logic [DATA_W-1:0]        preset_q,
  input logic                     ld_rise,
  input logic                     preset_force,
  input logic [NUM_CH*DATA_W-1:0] dac_q,
  input logic                     dout_en,
  input logic                     sdo,
  input logic                     pwr_down,
  input logic [1:0]               ref_sel,
  input logic [NUM_PAIR-1:0]      pair_pd,
  input logic [NUM_PAIR-1:0]      pair_fast
);

  assert_commit_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |=> (bit_cnt == 5'd0));

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    assert_pair_comp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_commit && frm_addr == ADDR_W'(8 + p)) |=>
      (pend_flat[(2*p+1)*DATA_W +: DATA_W] ==
       (~pend_flat[2*p*DATA_W +: DATA_W] & res_mask(RES))));
  end

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_rise && !preset_force) |=> $stable(dac_q));

  assert_preset_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    preset_force |=> (dac_q == {NUM_CH{$past(preset_q)}}));

  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_commit |=> $stable({pwr_down, ref_sel, pair_pd, pair_fast}));

  assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> !sdo);

endmodule

bind dac8_regctl dac8_regctl_chk #(.RES(RES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_commit (frame_commit),
  .frm_addr     (frm_addr),
  .bit_cnt      (bit_cnt),
  .pend_flat    (pend_flat),
  .preset_q     (preset_q),
  .ld_rise      (ld_rise),
  .preset_force (preset_force),
  .dac_q        (dac_q),
  .dout_en      (dout_en),
  .sdo          (sdo),
  .pwr_down     (pwr_down),
  .ref_sel      (ref_sel),
  .pair_pd      (pair_pd),
  .pair_fast    (pair_fast)
);

// File: tb/test_dac8_regctl.sv
module test_dac8_regctl;

  localparam int RES = 10;
  localparam int NCH = 8;
  localparam int DW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_n = 1'b1;
  logic sdi = 1'b0;
  logic ld = 1'b0;
  logic pre_n = 1'b1;

  wire [NCH*DW-1:0] dac_q;
  wire              sdo;
  wire              pwr_down;
  wire [1:0]        ref_sel;
  wire [3:0]        pair_pd;
  wire [3:0]        pair_fast;

  always #4 clk = ~clk;

  dac8_regctl #(.RES(RES)) i_dac8_regctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_n      (fs_n),
    .sdi       (sdi),
    .ld        (ld),
    .pre_n     (pre_n),
    .dac_q     (dac_q),
    .sdo       (sdo),
    .pwr_down  (pwr_down),
    .ref_sel   (ref_sel),
    .pair_pd   (pair_pd),
    .pair_fast (pair_fast)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  task automatic chk(input string req, input string what,
                     input logic [NCH*DW-1:0] act, input logic [NCH*DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_sh, m_preset;
  int m_pend[NCH];
  int m_out[NCH];
  int m_pd, m_den, m_ref, m_twos, m_ppd, m_pfast;
  int m_ldq, m_p1, m_p2;
  bit m_hist[$];

  function automatic int trunc(input int v);
    return ((v & 4095) >> (12 - RES)) << (12 - RES);
  endfunction

  function automatic int conv(input int v, input int tw);
    int r;
    r = trunc(v);
    if (tw != 0) r = r ^ 2048;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sh = 0; m_preset = 0;
      for (int i = 0; i < NCH; i++) begin m_pend[i] = 0; m_out[i] = 0; end
      m_pd = 0; m_den = 0; m_ref = 0; m_twos = 0; m_ppd = 0; m_pfast = 0;
      m_ldq = 0; m_p1 = 1; m_p2 = 1;
      m_hist.delete();
      for (int i = 0; i < 16; i++) m_hist.push_back(1'b0);
    end else begin
      if (m_p2 == 0 && ld) begin
        for (int i = 0; i < NCH; i++) m_out[i] = m_preset;
      end else if (ld && m_ldq == 0) begin
        for (int i = 0; i < NCH; i++) m_out[i] = m_pend[i];
      end
      if (fs_n && m_cnt == 16) begin
        int a, d, v;
        a = (m_sh >> 12) & 15;
        d = m_sh & 4095;
        v = conv(d, m_twos);
        if (a < 8) m_pend[a] = v;
        else if (a < 12) begin
          m_pend[(a - 8) * 2]     = v;
          m_pend[(a - 8) * 2 + 1] = trunc(4095 - v);
        end else if (a == 12) m_preset = trunc(d);
        else if (a == 13) begin
          m_pd = (d >> 4) & 1; m_den = (d >> 3) & 1;
          m_ref = (d >> 1) & 3; m_twos = d & 1;
        end else if (a == 14) begin
          m_ppd = (d >> 4) & 15; m_pfast = d & 15;
        end
      end
      if (!fs_n) begin
        m_sh = ((m_sh << 1) | int'(sdi)) & 65535;
        if (m_cnt < 17) m_cnt++;
      end else m_cnt = 0;
      m_p2 = m_p1; m_p1 = int'(pre_n); m_ldq = int'(ld);
      m_hist.push_back(sdi);
      void'(m_hist.pop_front());
    end
  end

  function automatic logic [NCH*DW-1:0] model_bus();
    logic [NCH*DW-1:0] b;
    for (int i = 0; i < NCH; i++) b[i*DW +: DW] = DW'(m_out[i]);
    return b;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "dac_q vs model", dac_q, model_bus());
      chk("R10", "sdo vs model", {95'd0, sdo},
          {95'd0, (m_den != 0) ? m_hist[0] : 1'b0});
      chk("R9", "status vs model", {85'd0, pwr_down, ref_sel, pair_pd, pair_fast},
          {85'd0, 1'(m_pd), 2'(m_ref), 4'(m_ppd), 4'(m_pfast)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input int addr, input int data, input int nbits = 16);
    int w;
    w = ((addr & 15) << 12) | (data & 4095);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      fs_n = 1'b0;
      sdi  = (i < 16) ? 1'((w >> (15 - i)) & 1) : 1'b1;
    end
    @(negedge clk);
    fs_n = 1'b1;
    sdi  = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ld();
    @(negedge clk); ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [NCH*DW-1:0] ch(input int c);
    return {84'd0, dac_q[c*DW +: DW]};
  endfunction

  initial begin
    logic [NCH*DW-1:0] prev;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {dac_q, sdo, pwr_down, ref_sel, pair_pd, pair_fast} == '0
        ? 96'd0 : 96'd1, 96'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "dac_q after reset", dac_q, '0);

    cur_req = "R9";
    send(13, 12'h008);

    cur_req = "R3";
    for (int c = 0; c < NCH; c++) send(c, 12'h100 * c + 12'h0F3);
    pulse_ld();
    chk("R3", "channel 2", ch(2), 96'h2F0);

    cur_req = "R5";
    send(3, 12'hABF);
    pulse_ld();
    chk("R5", "channel 3 truncated", ch(3), 96'hABC);

    cur_req = "R7";
    @(negedge clk); ld = 1'b1;
    prev = dac_q;
    send(2, 12'h555);
    repeat (2) @(negedge clk);
    chk("R7", "held ld no update", dac_q, prev);
    ld = 1'b0;
    pulse_ld();
    chk("R7", "new edge updates", ch(2), 96'h554);

    cur_req = "R4";
    send(8, 12'h123);
    send(11, 12'hF00);
    pulse_ld();
    chk("R4", "pair A", ch(0), 96'h120);
    chk("R4", "pair B complement", ch(1), 96'hEDC);
    chk("R4", "pair H complement", ch(7), 96'h0FC);

    cur_req = "R2";
    prev = dac_q;
    send(5, 12'h111, 15);
    send(5, 12'h222, 17);
    pulse_ld();
    chk("R2", "bad lengths discarded", dac_q, prev);

    cur_req = "R6";
    send(13, 12'h009);
    send(4, 12'h005);
    send(9, 12'h005);
    pulse_ld();
    chk("R6", "twos channel 4", ch(4), 96'h804);
    chk("R6", "twos pair C", ch(2), 96'h804);
    chk("R6", "twos pair D", ch(3), 96'h7F8);

    cur_req = "R8";
    send(12, 12'h3FF);
    @(negedge clk); pre_n = 1'b0;
    repeat (3) @(negedge clk);
    ld = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "preset on all", dac_q, {NCH{12'h3FC}});
    send(6, 12'h0F0);
    chk("R8", "preset holds under ld", dac_q, {NCH{12'h3FC}});
    ld = 1'b0; pre_n = 1'b1;
    repeat (3) @(negedge clk);
    cur_req = "R7";
    pulse_ld();
    chk("R7", "pending after preset", ch(6), 96'h8F0);

    cur_req = "R9";
    send(14, 12'h0A5);
    chk("R9", "pair_pd", {92'd0, pair_pd}, 96'hA);
    chk("R9", "pair_fast", {92'd0, pair_fast}, 96'h5);
    send(15, 12'hFFF);
    chk("R9", "addr 15 ignored", {92'd0, pair_pd}, 96'hA);
    send(13, 12'h017);
    chk("R9", "power-down and ref", {93'd0, pwr_down, ref_sel}, 96'h7);

    cur_req = "R10";
    send(0, 12'hA5A);
    chk("R10", "sdo quiet when disabled", {95'd0, sdo}, 96'd0);
    send(13, 12'h008);
    send(1, 12'h6C3);
    send(2, 12'h3A9);
    repeat (20) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog expired: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule